// File: doc/BRIEF.md
# Shared-Slave Bus Arbiter

This block decides which of up to five bus masters owns a single shared slave port. In each cycle every master shows whether it wants the slave (`req_i`), whether its current transfer is a burst of undefined length (`incr_i`), and whether it moves a data beat in that cycle (`beat_i`). The arbiter drives a one-hot grant vector and the index of the master that holds the slave. A grant is handed out in the cycle after the decision that picks its owner, and ownership moves only at defined points: when the owner stops requesting, when an undefined-length burst reaches its configured beat boundary, or when the owner has held the slave for the configured number of cycles.

Two arbitration schemes are selectable: fixed priority, with a 2-bit priority per master, and round-robin. When nobody requests, the slave can be left unconnected, parked on the master that used it last, or parked on a chosen master. A parked master starts its next access without a grant cycle. The configuration inputs are captured only while no transfer is in progress, so a change never alters a burst that is already running.

Top module: `slave_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gnt_o` is all zero and `idx_o` is 0.
- R2: `gnt_o` has at most one bit set, and when a bit is set `idx_o` is the position of that bit; with no grant `idx_o` is 0.
- R3: A master requesting an unconnected slave in cycle t sees its grant in cycle t+1; a grant held by a master that keeps requesting changes only at a rearbitration point (R6, R8 or the owner dropping its request).
- R4: With `arb_mode_i` equal to 1, the requester with the largest priority value wins, ties going to the lowest index; master i's priority is `prio_i[2i+1:2i]`.
- R5: With `arb_mode_i` equal to 0 (codes 2 and 3 behave the same), the search starts at the master after the last one granted (master 0 first after reset), wrapping around, and priority values have no effect.
- R6: Master i's break code is `brk_cfg_i[3i+2:3i]`: 1 allows rearbitration after every beat, 2, 3 and 4 after every 4, 8 and 16 beats; 0 and codes 5 to 7 never break. Beats are counted only in cycles where the owner has `req_i`, `incr_i` and `beat_i` high.
- R7: A transfer with `incr_i` low is never broken by its beat count.
- R8: With `slot_lim_i` equal to L (nonzero), an owner that requests for L consecutive granted cycles faces rearbitration in its L-th cycle; L equal to 0 removes the limit.
- R9: With `park_mode_i` equal to 0 (and code 3), when no master requests at a rearbitration point the grant goes to zero, so the next access pays one grant cycle.
- R10: With `park_mode_i` equal to 1, when no master requests the grant stays on the last owner, which then starts its next access with no wait.
- R11: With `park_mode_i` equal to 2, when no master requests the grant moves to master `park_idx_i`; an index of 5 or more leaves the slave unconnected.
- R12: Configuration inputs are taken only in cycles where the slave is not busy (no owner, or an owner not requesting); changes during a busy cycle do not affect the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NM | Per-master request for the slave |
| incr_i | input | NM | Per-master flag: current burst has undefined length |
| beat_i | input | NM | Per-master flag: a data beat moves this cycle |
| brk_cfg_i | input | 3*NM | Per-master burst break codes, 3 bits each |
| arb_mode_i | input | 2 | 1 = fixed priority, otherwise round-robin |
| park_mode_i | input | 2 | 0 = unconnected, 1 = last owner, 2 = fixed master |
| park_idx_i | input | IW | Master to park on when `park_mode_i` is 2 |
| slot_lim_i | input | SW | Maximum owned cycles per slot, 0 = no limit |
| prio_i | input | 2*NM | Per-master 2-bit priority values |
| gnt_o | output | NM | One-hot grant |
| idx_o | output | IW | Index of the granted master |

## Verification
The embedded assertions watch every cycle for a one-hot grant that agrees with the index, for a grant that moves only after a rearbitration decision, and for the parking result when no master requests in the unconnected and fixed-master policies. What only the directed scenarios can show is the choice of winner: the priority order and its tie rule, the rotation order of round-robin, the exact beat at which each break code hands over, the cycle at which the slot limit ends an ownership, the missing grant cycle for a parked master, and that settings changed in mid-burst are ignored.

// File: rtl/slave_arbiter.sv
module slave_arbiter #(
  parameter int NM = 5,
  parameter int PW = 2,
  parameter int SW = 8,
  parameter int IW = $clog2(NM)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NM-1:0]   req_i,
  input  logic [NM-1:0]   incr_i,
  input  logic [NM-1:0]   beat_i,
  input  logic [NM*3-1:0] brk_cfg_i,
  input  logic [1:0]      arb_mode_i,
  input  logic [1:0]      park_mode_i,
  input  logic [IW-1:0]   park_idx_i,
  input  logic [SW-1:0]   slot_lim_i,
  input  logic [NM*PW-1:0] prio_i,
  output logic [NM-1:0]   gnt_o,
  output logic [IW-1:0]   idx_o
);
  localparam int BW = 5;

  logic [NM*3-1:0]  brk_q;
  logic [1:0]       arb_q, park_q;
  logic [IW-1:0]    pidx_q;
  logic [SW-1:0]    lim_q;
  logic [NM*PW-1:0] prio_q;

  logic          own_vld_q;
  logic [IW-1:0] own_q, rr_q;
  logic [BW-1:0] beat_q;
  logic [SW-1:0] slot_q;

  logic busy;
  assign busy = own_vld_q & req_i[own_q];

  logic [NM*3-1:0]  brk_e;
  logic [1:0]       arb_e, park_e;
  logic [IW-1:0]    pidx_e;
  logic [SW-1:0]    lim_e;
  logic [NM*PW-1:0] prio_e;
  assign brk_e  = busy ? brk_q  : brk_cfg_i;
  assign arb_e  = busy ? arb_q  : arb_mode_i;
  assign park_e = busy ? park_q : park_mode_i;
  assign pidx_e = busy ? pidx_q : park_idx_i;
  assign lim_e  = busy ? lim_q  : slot_lim_i;
  assign prio_e = busy ? prio_q : prio_i;

  logic [2:0]    own_code;
  logic [BW-1:0] brk_len;
  assign own_code = brk_e[own_q*3 +: 3];
  always_comb begin
    case (own_code)
      3'd1:    brk_len = 5'd1;
      3'd2:    brk_len = 5'd4;
      3'd3:    brk_len = 5'd8;
      3'd4:    brk_len = 5'd16;
      default: brk_len = 5'd0;
    endcase
  end

  logic beat_hit, brk_pt, slot_pt, rearb;
  assign beat_hit = busy & incr_i[own_q] & beat_i[own_q];
  assign brk_pt   = beat_hit & (brk_len != '0) &
                    (({1'b0, beat_q} + 1'b1) == {1'b0, brk_len});
  assign slot_pt  = busy & (lim_e != '0) &
                    (({1'b0, slot_q} + 1'b1) == {1'b0, lim_e});
  assign rearb    = ~busy | brk_pt | slot_pt;

  logic          any_req, f_fp, f_rr;
  logic [PW-1:0] best;
  logic [IW-1:0] win_fp, win_rr, win;
  assign any_req = |req_i;

  always_comb begin
    win_fp = '0;
    win_rr = '0;
    f_fp   = 1'b0;
    f_rr   = 1'b0;
    best   = '0;
    for (int i = 0; i < NM; i++) begin
      if (req_i[i] && (!f_fp || prio_e[i*PW +: PW] > best)) begin
        f_fp   = 1'b1;
        best   = prio_e[i*PW +: PW];
        win_fp = IW'(i);
      end
    end
    for (int k = 1; k <= NM; k++) begin
      int j;
      j = int'(rr_q) + k;
      if (j >= NM) j = j - NM;
      if (!f_rr && req_i[j]) begin
        f_rr   = 1'b1;
        win_rr = IW'(j);
      end
    end
  end

  assign win = (arb_e == 2'd1) ? win_fp : win_rr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q  <= '0;
      arb_q  <= '0;
      park_q <= '0;
      pidx_q <= '0;
      lim_q  <= '0;
      prio_q <= '0;
    end else if (!busy) begin
      brk_q  <= brk_cfg_i;
      arb_q  <= arb_mode_i;
      park_q <= park_mode_i;
      pidx_q <= park_idx_i;
      lim_q  <= slot_lim_i;
      prio_q <= prio_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld_q <= 1'b0;
      own_q     <= '0;
      rr_q      <= IW'(NM - 1);
      beat_q    <= '0;
      slot_q    <= '0;
    end else if (rearb) begin
      beat_q <= '0;
      slot_q <= '0;
      if (any_req) begin
        own_vld_q <= 1'b1;
        own_q     <= win;
        rr_q      <= win;
      end else begin
        case (park_e)
          2'd1: ;
          2'd2: begin
            own_vld_q <= int'(pidx_e) < NM;
            own_q     <= pidx_e;
          end
          default: own_vld_q <= 1'b0;
        endcase
      end
    end else begin
      beat_q <= beat_q + BW'(beat_hit);
      slot_q <= slot_q + 1'b1;
    end
  end

  assign gnt_o = own_vld_q ? (NM'(1) << own_q) : '0;
  assign idx_o = own_vld_q ? own_q : '0;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  p_idx_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_o) |-> gnt_o[idx_o]);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rearb |=> $stable(gnt_o));

  p_park_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_req && (park_e == 2'd0 || park_e == 2'd3)) |=> (gnt_o == '0));

  p_park_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_req && park_e == 2'd2 && int'(pidx_e) < NM) |=>
      (gnt_o == (NM'(1) << $past(pidx_e))));
endmodule

// File: tb/test_slave_arbiter.sv
module test_slave_arbiter;
  localparam int PERIOD = 10;
  localparam int NM = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NM-1:0]   req, incr, beat;
  logic [NM*3-1:0] brk;
  logic [1:0]      arb, park;
  logic [2:0]      pidx;
  logic [7:0]      lim;
  logic [NM*2-1:0] prio;
  logic [NM-1:0]   gnt;
  logic [2:0]      idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  slave_arbiter i_slave_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .incr_i(incr), .beat_i(beat),
    .brk_cfg_i(brk), .arb_mode_i(arb), .park_mode_i(park), .park_idx_i(pidx),
    .slot_lim_i(lim), .prio_i(prio), .gnt_o(gnt), .idx_o(idx)
  );

  task automatic step;
    @(negedge clk);
  endtask

  task automatic chk_own(input int exp, input string tag);
    logic [NM-1:0] eg;
    logic [2:0] ei;
    eg = (exp < 0) ? '0 : (NM'(1) << exp);
    ei = (exp < 0) ? 3'd0 : exp[2:0];
    checks++;
    if (gnt !== eg || idx !== ei) begin
      errors++;
      $display("FAIL %s: gnt=%b idx=%0d expected gnt=%b idx=%0d", tag, gnt, idx, eg, ei);
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    req = '0; incr = '0; beat = '0; brk = '0;
    arb = 2'd0; park = 2'd0; pidx = 3'd0; lim = 8'd0; prio = '0;
    repeat (2) step();
    chk_own(-1, "R1 grant during reset");
    rst_n = 1'b1;
    step();
    chk_own(-1, "R1 grant after reset");
  endtask

  task automatic t_park_none;
    do_reset();
    req = 5'b00100;
    chk_own(-1, "R9 no grant before decision");
    step();
    chk_own(2, "R3 grant one cycle after request");
    req = '0;
    step();
    chk_own(-1, "R9 disconnected when idle");
    park = 2'd3;
    step();
    chk_own(-1, "R9 code 3 stays disconnected");
  endtask

  task automatic t_park_last;
    do_reset();
    park = 2'd1;
    req = 5'b00010;
    step();
    chk_own(1, "R10 first grant");
    req = '0;
    step();
    chk_own(1, "R10 parked on last owner");
    step();
    chk_own(1, "R10 still parked");
    req = 5'b00010;
    chk_own(1, "R10 no wait for parked master");
    step();
    chk_own(1, "R10 parked master keeps grant");
    req = 5'b01000;
    step();
    chk_own(3, "R10 other master takes over");
  endtask

  task automatic t_park_fixed;
    do_reset();
    park = 2'd2; pidx = 3'd3;
    req = 5'b00001;
    step();
    chk_own(0, "R11 requester granted");
    req = '0;
    step();
    chk_own(3, "R11 parked on fixed master");
    pidx = 3'd6;
    req = 5'b00010;
    step();
    chk_own(1, "R11 requester granted again");
    req = '0;
    step();
    chk_own(-1, "R11 out-of-range index disconnects");
  endtask

  task automatic t_fixed_prio;
    do_reset();
    arb = 2'd1;
    prio = 10'b10_00_11_11_01;
    req = 5'b11111;
    step();
    chk_own(1, "R4 highest priority tie to lowest index");
    req[1] = 1'b0;
    step();
    chk_own(2, "R4 next highest priority");
    req[2] = 1'b0;
    step();
    chk_own(4, "R4 priority 2 beats 1 and 0");
    req[4] = 1'b0;
    step();
    chk_own(0, "R4 priority 1 beats 0");
  endtask

  task automatic t_round_robin;
    do_reset();
    arb = 2'd0;
    prio = 10'b11_00_00_00_00;
    brk = {5{3'd1}};
    incr = '1; beat = '1; req = '1;
    for (int s = 0; s < 10; s++) begin
      step();
      chk_own(s % NM, $sformatf("R5 rotation sample %0d", s));
    end
  endtask

  task automatic t_break(input logic [2:0] code, input int len);
    do_reset();
    brk = {12'd0, code};
    incr = 5'b00011; beat = 5'b00011; req = 5'b00011;
    if (len == 0) begin
      for (int s = 0; s < 24; s++) begin
        step();
        chk_own(0, $sformatf("R6 code %0d never breaks, sample %0d", code, s));
      end
    end else begin
      for (int s = 0; s <= len; s++) begin
        step();
        chk_own((s < len) ? 0 : 1, $sformatf("R6 code %0d sample %0d", code, s));
      end
    end
  endtask

  task automatic t_beat_gaps;
    do_reset();
    brk = {12'd0, 3'd2};
    incr = 5'b00011; req = 5'b00011; beat = 5'b00010;
    step();
    chk_own(0, "R6 grant for gapped burst");
    repeat (3) step();
    chk_own(0, "R6 idle cycles do not count as beats");
    beat = 5'b00011;
    repeat (3) step();
    chk_own(0, "R6 three beats not yet a boundary");
    step();
    chk_own(1, "R6 boundary after fourth beat");
  endtask

  task automatic t_slot;
    do_reset();
    brk = {12'd0, 3'd1};
    lim = 8'd5;
    incr = 5'b00000; beat = 5'b00011; req = 5'b00011;
    for (int s = 0; s <= 5; s++) begin
      step();
      chk_own((s < 5) ? 0 : 1, $sformatf("R8 R7 slot limit 5 sample %0d", s));
    end
    do_reset();
    brk = {12'd0, 3'd1};
    incr = 5'b00000; beat = 5'b00011; req = 5'b00011;
    for (int s = 0; s < 30; s++) begin
      step();
      chk_own(0, $sformatf("R7 R8 no limit, defined burst sample %0d", s));
    end
  endtask

  task automatic t_cfg_hold;
    do_reset();
    brk = {12'd0, 3'd2};
    incr = 5'b00011; beat = 5'b00011; req = 5'b00011;
    step();
    chk_own(0, "R12 burst starts");
    brk = '0;
    lim = 8'd1;
    arb = 2'd1;
    prio = 10'b00_00_00_00_11;
    for (int s = 1; s <= 4; s++) begin
      step();
      chk_own((s < 4) ? 0 : 1, $sformatf("R12 held config sample %0d", s));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_park_none();
    t_park_last();
    t_park_fixed();
    t_fixed_prio();
    t_round_robin();
    t_break(3'd1, 1);
    t_break(3'd2, 4);
    t_break(3'd3, 8);
    t_break(3'd4, 16);
    t_break(3'd0, 0);
    t_break(3'd6, 0);
    t_beat_gaps();
    t_slot();
    t_cfg_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule